// File: doc/BRIEF.md
# Double-Buffered I2C Slave Transmitter

This block is the read side of an I2C target. A master addresses it with a 7-bit address and the read direction bit, and the block then returns data bytes on SDA. SCL and SDA are sampled on the system clock. A holding register sits in front of the output shift register, so the host logic can supply the next byte while the current one is still going out on the bus.

The host learns that it may write through a buffer-empty flag. This flag follows the holding register and not the wire. It rises once when the address is acknowledged. It rises again each time a byte is copied from the holding register into the shift register. The block keeps no byte count, so a read of N bytes raises N+1 requests. The last byte written is dropped when the master ends the read with NACK. If the shift register needs a byte and none is waiting, the block holds SCL low until the host supplies one. Both lines are open-drain and are modelled as drive-low enables.

Top module: `i2c_slave_tx`

## Requirements
- R1: After reset, scl_oe_o, sda_oe_o, txe_o, irq_o and sta_o are all 0.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start always begins a fresh address phase, including a start that follows a stop.
- R3: The address arrives MSB first as 7 bits, followed by a direction bit where 1 means read. Only a match with own_addr_i plus read=1 is acknowledged: sda_oe_o is 1 for the whole 9th clock. A wrong address or the write direction gets no ACK and sets no flag.
- R4: sta_o goes to 1 on the 8th SCL rising edge of a matching read address. It returns to 0 on the next SCL falling edge, when the ACK is driven.
- R5: txe_o goes to 1 when the address ACK is driven, which requests the first byte. An accepted host write (wr_en_i) clears txe_o.
- R6: Each copy of the holding register into the shift register sets txe_o again, before that byte appears on the bus. A read of N bytes therefore produces N+1 rising edges of txe_o.
- R7: Data goes out MSB first. sda_oe_o changes only while SCL is low. The master's ACK (SDA low) or NACK (SDA high) is sampled on the 9th SCL rising edge of each byte.
- R8: When the shift register needs a byte and the holding register is empty, scl_oe_o holds SCL low until the host writes. With the holding register already full, SCL is never stretched.
- R9: A NACK from the master discards any byte in the holding register. That byte is never sent, and the next transfer starts with a byte written for it.
- R10: irq_o is 1 exactly when txe_o is 1 and tx_ie_i is 1. With tx_ie_i at 0, irq_o stays 0 through a whole transfer.
- R11: Host writes are ignored unless the block is in an addressed read, from the address ACK until a NACK, stop or start.
- R12: A stop or a start clears txe_o, including a request that is still pending after a NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | Pull SDA low (ACK or data 0) |
| own_addr_i | input | ADDR_W | Own 7-bit target address |
| wr_en_i | input | 1 | Host write strobe to the holding register |
| wr_data_i | input | DATA_W | Host write data |
| tx_ie_i | input | 1 | Transmit interrupt enable |
| txe_o | output | 1 | Holding register wants a byte |
| irq_o | output | 1 | Transmit interrupt request |
| sta_o | output | 1 | Own read address seen, ACK pending |

## Verification
The hardest state to reach from the ports is the master's NACK arriving while a byte the host wrote for request N+1 is still in the holding register. A second case is the same NACK arriving with that request still unanswered. The bench reaches both with a host model that answers every buffer-empty request, with an option to also answer the surplus one. It shows the dropped byte is gone by running a fresh transfer whose first byte must differ from it. A host model with a long delay, plus a write issued while the bus is idle, forces the slave to stretch SCL at the first byte.

// File: rtl/i2c_stx_pkg.sv
package i2c_stx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_HOLD,
    ST_SHIFT,
    ST_MACK
  } stx_state_e;
endpackage

// File: rtl/i2c_stx_sync.sv
module i2c_stx_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  // idle bus is high, so reset to ones
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) stg <= '1;
    else         stg <= {stg[STAGES-2:0], d_i};

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2c_stx_events.sv
module i2c_stx_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end

  assign scl_lvl_o = scl_i;
  assign sda_lvl_o = sda_i;
  assign start_o   = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o    = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_o    = scl_i & ~scl_q;
  assign fall_o    = ~scl_i & scl_q;
endmodule

// File: rtl/i2c_stx_txbuf.sv
module i2c_stx_txbuf #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          discard_i,
  input  logic          arm_i,
  input  logic          load_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] hold_o,
  output logic          vld_o,
  output logic          txe_o
);
  logic [DW-1:0] hold_q;
  logic          vld_q, txe_q;

  // write wins over a same-cycle load: the new byte stays held
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      hold_q <= '0;
      vld_q  <= 1'b0;
      txe_q  <= 1'b0;
    end else if (clr_i) begin
      vld_q <= 1'b0;
      txe_q <= 1'b0;
    end else begin
      if (discard_i) vld_q <= 1'b0;
      if (arm_i)     txe_q <= 1'b1;
      if (load_i) begin
        vld_q <= 1'b0;
        txe_q <= 1'b1;
      end
      if (wr_i) begin
        hold_q <= wdata_i;
        vld_q  <= 1'b1;
        txe_q  <= 1'b0;
      end
    end

  assign hold_o = hold_q;
  assign vld_o  = vld_q;
  assign txe_o  = txe_q;

  AST_LOAD_REQUESTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !wr_i && !clr_i) |=> txe_o); // R6
  AST_WRITE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> (vld_o && !txe_o)); // R5
endmodule

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx
  import i2c_stx_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tx_ie_i,
  output logic              txe_o,
  output logic              irq_o,
  output logic              sta_o
);
  localparam int FRAME_W = ADDR_W + 1;
  localparam int MAXB    = (FRAME_W > DATA_W) ? FRAME_W : DATA_W;
  localparam int CNT_W   = $clog2(MAXB + 1);

  logic [1:0] line_raw, line_syn;
  logic scl_s, sda_s, start, stop, rise, fall, clr;
  logic load, arm, discard, wr_ok, hold_vld;
  logic [DATA_W-1:0] hold;
  logic [DATA_W-1:0] sh;
  logic [ADDR_W-1:0] addr_sh;
  logic [CNT_W-1:0]  cnt;
  logic sta_q, scl_oe_q;
  stx_state_e state;

  assign line_raw = {scl_i, sda_i};

  i2c_stx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(line_raw), .q_o(line_syn)
  );

  i2c_stx_events u_evt (
    .clk_i, .rst_ni,
    .scl_i(line_syn[1]), .sda_i(line_syn[0]),
    .scl_lvl_o(scl_s), .sda_lvl_o(sda_s),
    .start_o(start), .stop_o(stop), .rise_o(rise), .fall_o(fall)
  );

  assign clr     = start | stop;
  assign load    = hold_vld & ~clr &
                   ((state == ST_HOLD) | (fall & ((state == ST_AACK) | (state == ST_MACK))));
  assign arm     = ~clr & (state == ST_ADDR) & fall & (cnt == CNT_W'(FRAME_W));
  assign discard = ~clr & (state == ST_MACK) & rise & sda_s;
  assign wr_ok   = wr_en_i & ((state == ST_AACK) | (state == ST_HOLD) |
                              (state == ST_SHIFT) | (state == ST_MACK));

  i2c_stx_txbuf #(.DW(DATA_W)) u_buf (
    .clk_i, .rst_ni,
    .clr_i(clr), .discard_i(discard), .arm_i(arm), .load_i(load),
    .wr_i(wr_ok), .wdata_i(wr_data_i),
    .hold_o(hold), .vld_o(hold_vld), .txe_o(txe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      addr_sh  <= '0;
      sh       <= '0;
      sta_q    <= 1'b0;
      scl_oe_q <= 1'b0;
    end else begin
      // lags HOLD by a cycle so SDA settles before SCL is released
      scl_oe_q <= (state == ST_HOLD);
      if (start) begin
        state <= ST_ADDR;
        cnt   <= '0;
        sta_q <= 1'b0;
      end else if (stop) begin
        state <= ST_IDLE;
        cnt   <= '0;
        sta_q <= 1'b0;
      end else if (load) begin
        sh    <= hold;
        cnt   <= '0;
        state <= ST_SHIFT;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (rise) begin
              addr_sh <= {addr_sh[ADDR_W-2:0], sda_s};
              cnt     <= cnt + CNT_W'(1);
              if (cnt == CNT_W'(ADDR_W)) begin
                if (addr_sh == own_addr_i && sda_s) sta_q <= 1'b1;
                else                                state <= ST_IDLE;
              end
            end else if (fall && cnt == CNT_W'(FRAME_W)) begin
              state <= ST_AACK;
              sta_q <= 1'b0;
            end
          end
          ST_AACK: if (fall) state <= ST_HOLD;
          ST_SHIFT: begin
            if (fall) begin
              if (cnt == CNT_W'(DATA_W - 1)) state <= ST_MACK;
              else begin
                cnt <= cnt + CNT_W'(1);
                sh  <= {sh[DATA_W-2:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (rise && sda_s) state <= ST_IDLE;
            else if (fall)     state <= ST_HOLD;
          end
          default: ;
        endcase
      end
    end

  assign sda_oe_o = (state == ST_AACK) | ((state == ST_SHIFT) & ~sh[DATA_W-1]);
  assign scl_oe_o = scl_oe_q;
  assign irq_o    = txe_o & tx_ie_i;
  assign sta_o    = sta_q;

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && !$past(clr)) |-> !$past(scl_s)); // R7
  AST_ACK_WITH_REQUEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sta_o) && !$past(clr)) |-> (sda_oe_o && txe_o)); // R5
  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (!txe_o && !sda_oe_o && !sta_o)); // R12
endmodule

// File: tb/sim_i2c_slave_tx.sv
`timescale 1ns/1ps
module sim_i2c_slave_tx;
  localparam int Q = 40;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, txe, irq, sta;
  logic wr_en = 1'b0, tx_ie = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic scl_bus, sda_bus;
  assign scl_bus = scl_m & ~scl_oe;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_slave_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .own_addr_i(OWN),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .tx_ie_i(tx_ie),
    .txe_o(txe), .irq_o(irq), .sta_o(sta)
  );

  int checks = 0, fails = 0;
  logic [7:0] tx [8];
  logic [7:0] rx [8];

  // host model
  logic host_en = 1'b0, host_extra = 1'b0;
  int host_delay = 0, host_n = 0, hidx = 0;
  initial forever begin
    @(negedge clk);
    if (host_en && txe === 1'b1 && (hidx < host_n || host_extra)) begin
      repeat (host_delay) @(negedge clk);
      wr_data = (hidx < host_n) ? tx[hidx] : 8'hEE;
      hidx++;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
    end
  end

  // monitors
  int txe_r = 0, irq_r = 0, sta_r = 0, stretch = 0, sda_viol = 0;
  logic txe_d = 1'b0, irq_d = 1'b0, sta_d = 1'b0, sda_d = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (txe && !txe_d) txe_r <= txe_r + 1;
    if (irq && !irq_d) irq_r <= irq_r + 1;
    if (sta && !sta_d) sta_r <= sta_r + 1;
    if (scl_m && !scl_bus) stretch <= stretch + 1;
    if ((sda_oe != sda_d) && scl_bus) sda_viol <= sda_viol + 1;
    txe_d <= txe; irq_d <= irq; sta_d <= sta; sda_d <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic realign();
    @(negedge clk);
    #1;
  endtask

  task automatic gap();
    repeat (100) @(negedge clk);
    #1;
  endtask

  task automatic bit_clk(input logic b, output logic s);
    sda_m = b; #Q;
    scl_m = 1'b1;
    wait (scl_bus === 1'b1);
    realign();
    #Q; s = sda_bus;
    #Q; scl_m = 1'b0;
    #Q;
  endtask

  task automatic m_start();
    sda_m = 1'b1; scl_m = 1'b1; #Q;
    sda_m = 1'b0; #Q;
    scl_m = 1'b0; #Q;
  endtask

  task automatic m_stop();
    sda_m = 1'b0; #Q;
    scl_m = 1'b1;
    wait (scl_bus === 1'b1);
    realign();
    #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic xfer(input logic [6:0] a, input logic rd, input int n,
                      input logic do_stop, output logic aack);
    logic s;
    logic [7:0] b;
    m_start();
    for (int i = 6; i >= 0; i--) bit_clk(a[i], s);
    bit_clk(rd, s);
    bit_clk(1'b1, s);
    aack = ~s;
    if (aack) begin
      for (int k = 0; k < n; k++) begin
        b = 8'h00;
        for (int j = 0; j < 8; j++) begin
          bit_clk(1'b1, s);
          b = {b[6:0], s};
        end
        rx[k] = b;
        bit_clk((k == n - 1), s);
      end
    end
    if (do_stop) m_stop();
  endtask

  task automatic host_setup(input int dly, input int n, input logic extra);
    hidx = 0; host_delay = dly; host_n = n; host_extra = extra; host_en = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 txe", txe, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sta", sta, 0);
  endtask

  task automatic t_basic();
    int t0, i0, s0, st0, v0;
    logic ak;
    tx[0] = 8'hA1; tx[1] = 8'h3C; tx[2] = 8'h80; tx[3] = 8'h01;
    host_setup(0, 4, 1'b1);
    tx_ie = 1'b1;
    t0 = txe_r; i0 = irq_r; s0 = sta_r; st0 = stretch; v0 = sda_viol;
    xfer(OWN, 1'b1, 4, 1'b1, ak);
    #Q;
    chk("R3 address ack", ak, 1);
    chk("R7 byte0", rx[0], 8'hA1);
    chk("R7 byte1", rx[1], 8'h3C);
    chk("R7 byte2", rx[2], 8'h80);
    chk("R7 byte3", rx[3], 8'h01);
    chk("R6 requests N+1", txe_r - t0, 5);
    chk("R10 irq requests", irq_r - i0, 5);
    chk("R4 start flag pulses", sta_r - s0, 1);
    chk("R4 start flag low after", sta, 0);
    chk("R8 no stretch when full", stretch - st0, 0);
    chk("R7 sda only moves with scl low", sda_viol - v0, 0);
    chk("R12 txe clear after stop", txe, 0);
    host_en = 1'b0; gap();
  endtask

  task automatic t_irq_masked();
    int t0, i0;
    logic ak;
    tx[0] = 8'h69; tx[1] = 8'h96;
    host_setup(0, 2, 1'b1);
    tx_ie = 1'b0;
    t0 = txe_r; i0 = irq_r;
    xfer(OWN, 1'b1, 2, 1'b1, ak);
    #Q;
    chk("R10 masked irq", irq_r - i0, 0);
    chk("R6 requests N+1 masked", txe_r - t0, 3);
    chk("R7 masked byte1", rx[1], 8'h96);
    tx_ie = 1'b1;
    host_en = 1'b0; gap();
  endtask

  task automatic t_mismatch();
    int t0, s0;
    logic ak;
    host_setup(0, 1, 1'b0);
    tx[0] = 8'h11;
    t0 = txe_r; s0 = sta_r;
    xfer(OWN ^ 7'h01, 1'b1, 1, 1'b1, ak);
    chk("R3 wrong address nack", ak, 0);
    xfer(OWN, 1'b0, 1, 1'b1, ak);
    chk("R3 write direction nack", ak, 0);
    #Q;
    chk("R3 no request on mismatch", txe_r - t0, 0);
    chk("R4 no start flag on mismatch", sta_r - s0, 0);
    host_en = 1'b0; gap();
  endtask

  task automatic t_stretch();
    int st0;
    logic ak;
    host_en = 1'b0;
    wr_data = 8'h33; wr_en = 1'b1;
    realign();
    wr_en = 1'b0;
    tx[0] = 8'hC5; tx[1] = 8'h5C;
    host_setup(60, 2, 1'b1);
    st0 = stretch;
    xfer(OWN, 1'b1, 2, 1'b1, ak);
    #Q;
    chk("R11 idle write ignored, byte0", rx[0], 8'hC5);
    chk("R8 stretched while empty", (stretch - st0) > 0, 1);
    chk("R8 byte1 after stretch", rx[1], 8'h5C);
    host_en = 1'b0; gap();
  endtask

  task automatic t_nack_discard();
    int t0;
    logic ak;
    tx[0] = 8'h96;
    host_setup(0, 1, 1'b1);
    t0 = txe_r;
    xfer(OWN, 1'b1, 1, 1'b0, ak);
    realign();
    chk("R9 byte sent", rx[0], 8'h96);
    chk("R6 requests N+1 single", txe_r - t0, 2);
    chk("R9 slave released sda", sda_oe, 0);
    m_stop();
    host_en = 1'b0; gap();
    tx[0] = 8'h4B;
    host_setup(0, 1, 1'b0);
    xfer(OWN, 1'b1, 1, 1'b1, ak);
    chk("R2 restart after stop acked", ak, 1);
    chk("R9 discarded byte not sent", rx[0], 8'h4B);
    host_en = 1'b0; gap();
  endtask

  task automatic t_stop_clears();
    logic ak;
    tx[0] = 8'h5F;
    host_setup(0, 1, 1'b0);
    xfer(OWN, 1'b1, 1, 1'b0, ak);
    realign();
    chk("R6 request pending after nack", txe, 1);
    m_stop();
    #Q;
    chk("R12 stop clears request", txe, 0);
    chk("R10 irq follows cleared txe", irq, 0);
    host_en = 1'b0; gap();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    gap();
    t_basic();
    t_irq_masked();
    t_mismatch();
    t_stretch();
    t_nack_discard();
    t_stop_clears();
    summary();
    $finish;
  end
endmodule